// File: doc/BRIEF.md
# MDIO Management Master with a Single Command Word

This block runs clause 22 management transactions toward external PHYs on a two-wire MDC/MDIO bus. Software controls it through one 32-bit command register. A transaction is packed into that word: start code, opcode, PHY address, register address and the 16-bit data. Software writes the fields with bit 31 clear, then writes the same word again with bit 31 set to launch the frame.

Bit 31 reads back as one while the frame is on the wire. The hardware clears it when the frame ends, and software polls it to learn of completion. On a read, the 16 bits returned by the PHY replace bits 15:0 of the same register when the bit clears. The block makes MDC from the system clock with a parameterised divider. It sends a preamble of ones, shifts out the header, and controls the tristate enable of MDIO so that the PHY can drive the bus during turnaround and data on reads.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the command register reads 0x00000000, MDC is low and MDIO is released (enable low).
- R2: A register write with bit 31 clear stores the whole word, which reads back unchanged, and causes no MDC activity. The fields are: register address in bits 29:25, PHY address in bits 24:20, opcode in bits 19:18, start code in bits 17:16 and data in bits 15:0.
- R3: A write with bit 31 set while idle starts a frame. Bit 31 reads 1 from the next cycle until the frame ends, and the hardware then clears it.
- R4: Each frame begins with PREAMBLE_LEN ones (default 32). It continues with the start code (bits 17:16), the opcode (bits 19:18), the PHY address and then the register address, each sent MSB first.
- R5: For any opcode other than binary 10, the master drives every bit of the frame. The turnaround is binary 10 and is followed by data bits 15:0, MSB first. The data field of the register is unchanged after completion.
- R6: Opcode binary 10 is a read. The master releases MDIO for the two turnaround bits and the 16 data bits. It samples the 16 data bits MSB first on rising MDC edges and places them in bits 15:0 when bit 31 clears.
- R7: MDC has a period of 2*CLK_DIV system clocks while a frame runs and stays low while idle. MDIO output and enable change only while MDC is low, so they are stable across every high phase of MDC.
- R8: A register write while bit 31 is set is ignored. The register contents and the frame in progress are unaffected.
- R9: Each frame has exactly PREAMBLE_LEN+32 rising MDC edges and ends with MDC low.
- R10: While no frame runs, the MDIO output enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the command register |
| reg_wdata | input | 32 | Command word to write |
| reg_rdata | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value to the pad |
| mdio_oe | output | 1 | MDIO output enable (high drives the pad) |

## Verification
Transactions are taken from a vector table that alternates writes and reads. The table covers all-zero and all-one PHY and register addresses, alternating bit patterns, and data with only the top or bottom bit differing. These patterns separate a correct MSB-first shift from a reversed one and from a header with swapped fields. Read entries return data that differs from the written field, which shows whether the sampled word really lands in bits 15:0. The enable pattern recorded on each rising MDC edge shows where the bus is released. Directed cases then cover the reset state, a write with bit 31 clear that must stay silent, and a write that arrives while a frame is running and must change neither the register nor the bits on the wire.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int CMD_W      = 32;
  localparam int BUSY_POS   = 31;
  localparam int REGAD_HI   = 29;
  localparam int REGAD_LO   = 25;
  localparam int PHYAD_HI   = 24;
  localparam int PHYAD_LO   = 20;
  localparam int OPC_HI     = 19;
  localparam int OPC_LO     = 18;
  localparam int STC_HI     = 17;
  localparam int STC_LO     = 16;
  localparam int DATA_W     = 16;
  localparam int HDR_BITS   = 32;

  localparam logic [1:0] OPC_RD   = 2'b10;
  localparam logic [1:0] TA_DRIVE = 2'b10;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SHIFT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          term;

  assign term = (cnt_q == CW'(CLK_DIV - 1));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = run && term && !mdc_q;
  assign fall_stb = run && term &&  mdc_q;
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_cmd_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CMD_W-1:0]  cmd,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              run,
  output logic              done,
  output logic [DATA_W-1:0] rd_word,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int NBITS      = PREAMBLE_LEN + HDR_BITS;
  localparam int IW         = $clog2(NBITS + 1);
  localparam int TA_START   = PREAMBLE_LEN + 14;
  localparam int DATA_START = PREAMBLE_LEN + 16;

  seq_state_e         st_q, st_d;
  logic [IW-1:0]      idx_q, idx_d;
  logic [NBITS-1:0]   sh_q, sh_d;
  logic               rd_q, rd_d;
  logic [DATA_W-1:0]  cap_q, cap_d;
  logic               last_bit;
  logic               start_rd;
  logic [NBITS-1:0]   frame_load;

  assign start_rd = (cmd[OPC_HI:OPC_LO] == OPC_RD);
  assign frame_load = {{PREAMBLE_LEN{1'b1}},
                       cmd[STC_HI:STC_LO],
                       cmd[OPC_HI:OPC_LO],
                       cmd[PHYAD_HI:PHYAD_LO],
                       cmd[REGAD_HI:REGAD_LO],
                       start_rd ? 2'b11 : TA_DRIVE,
                       start_rd ? {DATA_W{1'b1}} : cmd[DATA_W-1:0]};
  assign last_bit = (idx_q == IW'(NBITS - 1));

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    sh_d  = sh_q;
    rd_d  = rd_q;
    cap_d = cap_q;
    done  = 1'b0;
    case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          st_d  = SEQ_SHIFT;
          idx_d = '0;
          sh_d  = frame_load;
          rd_d  = start_rd;
        end
      end
      default: begin
        if (rise_stb && rd_q && (idx_q >= IW'(DATA_START)))
          cap_d = {cap_q[DATA_W-2:0], mdio_i};
        if (fall_stb) begin
          if (last_bit) begin
            st_d = SEQ_IDLE;
            done = 1'b1;
          end else begin
            idx_d = idx_q + IW'(1);
            sh_d  = {sh_q[NBITS-2:0], 1'b0};
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      idx_q <= '0;
      sh_q  <= '0;
      rd_q  <= 1'b0;
      cap_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      rd_q  <= rd_d;
      cap_q <= cap_d;
    end
  end

  assign run     = (st_q == SEQ_SHIFT);
  assign rd_word = cap_q;
  assign mdio_o  = run && sh_q[NBITS-1];
  assign mdio_oe = run && !(rd_q && (idx_q >= IW'(TA_START)));
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CMD_W-1:0]  wdata,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_word,
  output logic [CMD_W-1:0]  word,
  output logic              start
);
  logic [CMD_W-1:0] word_q, word_d;
  logic             busy;
  logic             wr_en;
  logic             word_en;

  assign busy    = word_q[BUSY_POS];
  assign wr_en   = wr && !busy;
  assign word_en = wr_en || done;
  assign start   = wr_en && wdata[BUSY_POS];

  always_comb begin
    word_d = word_q;
    if (wr_en) begin
      word_d = wdata;
    end else if (done) begin
      word_d[BUSY_POS] = 1'b0;
      if (word_q[OPC_HI:OPC_LO] == OPC_RD)
        word_d[DATA_W-1:0] = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      word_q <= '0;
    else if (word_en)
      word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int CLK_DIV      = 4,
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              start;
  logic              run;
  logic              done;
  logic              rise_stb;
  logic              fall_stb;
  logic [DATA_W-1:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= 2'b00;
    else
      rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mdio_cmd_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr      (reg_wr),
    .wdata   (reg_wdata),
    .done    (done),
    .rd_word (rd_word),
    .word    (reg_rdata),
    .start   (start)
  );

  mdio_clk_gen #(
    .CLK_DIV (CLK_DIV)
  ) u_clk (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .run      (run),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame_seq #(
    .PREAMBLE_LEN (PREAMBLE_LEN)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .cmd      (reg_wdata),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .run      (run),
    .done     (done),
    .rd_word  (rd_word),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );
endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [31:0] reg_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  assert_mdc_low_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[31] |-> !mdc);

  assert_mdio_stable_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_busy_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_rdata[31]) && $past(reg_wr) && reg_rdata[31]) |-> $stable(reg_rdata));

  assert_fields_hold_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_rdata[31]) && reg_rdata[31]) |-> $stable(reg_rdata[30:0]));

  assert_released_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[31] |-> !mdio_oe);

  assert_mdc_rise_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> reg_rdata[31]);
endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_rdata (reg_rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/mdio_cmd_master_tb.sv
`timescale 1ns/1ps
module mdio_cmd_master_tb;
  localparam int DIV   = 2;
  localparam int PRE   = 32;
  localparam int NB    = PRE + 32;
  localparam int NVEC  = 6;

  // entry: {is_read, phy[4:0], regad[4:0], data[15:0]}
  localparam logic [26:0] VEC [NVEC] = '{
    {1'b0, 5'd1,  5'd0,  16'h1234},
    {1'b1, 5'd3,  5'd2,  16'hA5C3},
    {1'b0, 5'd31, 5'd31, 16'hFFFF},
    {1'b1, 5'd0,  5'd0,  16'h0001},
    {1'b0, 5'h15, 5'h0A, 16'h8001},
    {1'b1, 5'h1F, 5'h11, 16'h7FFE}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc;
  logic        mdio_i = 1'b1;
  logic        mdio_o;
  logic        mdio_oe;

  int total = 0;
  int bad = 0;
  int rise_cnt = 0;
  logic [NB-1:0] got_bits;
  logic [NB-1:0] got_oe;
  logic [15:0]   phy_data = '0;
  time t_r1, t_r2;

  always #2 clk = ~clk;

  mdio_cmd_master #(.CLK_DIV(DIV), .PREAMBLE_LEN(PRE)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // PHY side: record the line on each rising MDC edge
  initial begin
    forever begin
      @(posedge mdc);
      if (rise_cnt < NB) begin
        got_bits[NB-1-rise_cnt] = mdio_o;
        got_oe[NB-1-rise_cnt]   = mdio_oe;
      end
      if (rise_cnt == 1) t_r1 = $time;
      if (rise_cnt == 2) t_r2 = $time;
      rise_cnt = rise_cnt + 1;
    end
  end

  // PHY side: present read data after each falling MDC edge
  initial begin
    forever begin
      @(negedge mdc);
      if (rise_cnt >= PRE + 16 && rise_cnt < PRE + 32)
        mdio_i = phy_data[15 - (rise_cnt - PRE - 16)];
      else
        mdio_i = 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    total = total + 1;
    bad = bad + 1;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [31:0] w);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000; i++) begin
      if (!reg_rdata[31]) break;
      @(negedge clk);
    end
  endtask

  task automatic run_txn(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] dat, input bit intrude);
    logic [31:0] w;
    logic [31:0] exp_word;
    logic [NB-1:0] exp_bits;
    logic [NB-1:0] exp_oe;
    logic [1:0] opc;
    opc = rd ? 2'b10 : 2'b01;
    w = {2'b00, rg, phy, opc, 2'b01, (rd ? 16'h0000 : dat)};
    exp_bits = {{PRE{1'b1}}, 2'b01, opc, phy, rg, (rd ? 2'b11 : 2'b10),
                (rd ? 16'hFFFF : dat)};
    exp_oe = rd ? {{(PRE + 14){1'b1}}, 18'b0} : {NB{1'b1}};
    exp_word = {1'b0, w[30:16], (rd ? dat : w[15:0])};
    phy_data = dat;
    rise_cnt = 0;
    got_bits = '0;
    got_oe = '0;
    write_reg(w);
    write_reg(w | 32'h8000_0000);
    // R3: busy visible in the cycle after the start write
    check(reg_rdata[31] == 1'b1, "R3 busy set", {63'd0, reg_rdata[31]}, 64'd1);
    if (intrude) begin
      repeat (20) @(negedge clk);
      write_reg(32'hFFFF_FFFF);
      // R8: register unchanged by a write during the frame
      check(reg_rdata == (w | 32'h8000_0000), "R8 busy write ignored",
            {32'd0, reg_rdata}, {32'd0, w | 32'h8000_0000});
    end
    wait_idle();
    @(negedge clk);
    check(reg_rdata[31] == 1'b0, "R3 busy cleared", {63'd0, reg_rdata[31]}, 64'd0);
    check(rise_cnt == NB, "R9 rising edge count", 64'(rise_cnt), 64'(NB));
    check(mdc == 1'b0, "R9 MDC low at end", {63'd0, mdc}, 64'd0);
    check(mdio_oe == 1'b0, "R10 released when idle", {63'd0, mdio_oe}, 64'd0);
    check((got_bits[NB-1:NB-PRE-14] == exp_bits[NB-1:NB-PRE-14]),
          "R4 preamble and header", got_bits, exp_bits);
    check(got_oe == exp_oe, rd ? "R6 read release window" : "R5 write drives all",
          got_oe, exp_oe);
    if (!rd)
      check(got_bits == exp_bits, "R5 turnaround and data", got_bits, exp_bits);
    check(reg_rdata == exp_word, rd ? "R6 read data stored" : "R5 data field kept",
          {32'd0, reg_rdata}, {32'd0, exp_word});
    check((t_r2 - t_r1) == time'(2 * DIV * 4), "R7 MDC period",
          64'(t_r2 - t_r1), 64'(2 * DIV * 4));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(reg_rdata == 32'h0, "R1 register after reset", {32'd0, reg_rdata}, 64'd0);
    check(mdc == 1'b0, "R1 MDC low after reset", {63'd0, mdc}, 64'd0);
    check(mdio_oe == 1'b0, "R1 MDIO released after reset", {63'd0, mdio_oe}, 64'd0);

    // R2: write without start bit stores word and stays silent
    rise_cnt = 0;
    write_reg(32'h3ABC_5A5A);
    repeat (50) @(negedge clk);
    check(reg_rdata == 32'h3ABC_5A5A, "R2 stored word", {32'd0, reg_rdata},
          {32'd0, 32'h3ABC_5A5A});
    check(rise_cnt == 0, "R2 no MDC activity", 64'(rise_cnt), 64'd0);
    check(mdio_oe == 1'b0, "R10 idle enable low", {63'd0, mdio_oe}, 64'd0);

    // table of transactions
    for (int i = 0; i < NVEC; i++)
      run_txn(VEC[i][26], VEC[i][25:21], VEC[i][20:16], VEC[i][15:0], 1'b0);

    // R8: write arriving during a write frame and during a read frame
    run_txn(1'b0, 5'h0C, 5'h03, 16'h0F0F, 1'b1);
    run_txn(1'b1, 5'h07, 5'h1C, 16'hC33C, 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule